// File: doc/BRIEF.md
# Bit-Serial Register File and Datapath

This block is the arithmetic core of a very small processor that trades cycles for area. Sixteen 32-bit registers live in a bit-addressable store. Every operation streams its operands through a single one-bit logic slice and a carry flip-flop, least significant bit first. No word-wide bus or adder exists anywhere in the datapath. An operation takes 32 clock cycles. In exchange, each clock has to cover only one gate-level bit step, so the clock rate can be high.

A controller outside this block issues a one-cycle start pulse together with an operation code, a destination and two source register numbers. The block then computes one result bit per cycle. It presents each bit on a serial output, writes it into the destination bit in the same cycle, and gathers a zero indication on the way. A one-cycle done pulse marks the end of the operation. A load operation takes its operand from a serial input pin, so registers can be filled from outside without a parallel port. The result stream also lets the surrounding logic observe any register by copying it.

Top module: `bitser_datapath`

## Requirements
- R1: While reset is asserted and afterwards until the first start, busy_o, done_o and zero_o are 0.
- R2: Operation code 0 writes the 32-bit sum of the two source registers, modulo 2^32, into the destination (carry starts at 0).
- R3: Operation code 1 writes source A minus source B, modulo 2^32 (carry starts at 1, B bits inverted).
- R4: Operation codes 2, 3 and 4 write the bitwise AND, OR and XOR of the two sources.
- R5: Operation codes 5 and 7 copy source A unchanged into the destination; source B is not used.
- R6: Operation code 6 writes into the destination the bit present on ser_in_i in each bit cycle, bit k in the k-th busy cycle.
- R7: A start accepted at a clock edge makes busy_o high for exactly the next 32 cycles. In those cycles res_bit_o carries result bits 0 to 31 in order.
- R8: done_o is high for exactly one cycle, the cycle right after the last busy cycle. busy_o is low in that cycle.
- R9: At done, zero_o becomes 1 if all 32 result bits were 0 and 0 otherwise. It holds that value until the next done.
- R10: The destination may equal either source or both; the result is computed from the source values before the operation.
- R11: A start pulse while busy_o is high is ignored. It changes neither the running operation, its timing, nor any register.
- R12: Adding a register to itself produces that value shifted left by one bit, with bit 31 dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 copy, 6 serial load, 7 copy |
| rd_i | input | 4 | Destination register number |
| ra_i | input | 4 | Source A register number |
| rb_i | input | 4 | Source B register number |
| ser_in_i | input | 1 | Serial operand bit for the load operation |
| busy_o | output | 1 | High while result bits are being produced |
| res_bit_o | output | 1 | Current result bit, valid while busy_o is high |
| done_o | output | 1 | One-cycle pulse after the last result bit |
| zero_o | output | 1 | Zero indication of the last completed result |

## Verification
Eight values are loaded into registers through the serial load. They include all-zeros, all-ones, the sign bit alone, the largest positive value and mixed patterns. Every ordered pair of these values is run through all six main operations. The pairs separate carry propagation across the full word (all-ones plus one) from borrow handling (zero minus one) and from purely bitwise mistakes. After each operation, the destination is copied back out. This shows the serial write landed in the right register and bit order, and is not just visible on the output stream. Separate runs cover destination equal to a source, self-addition as a left shift, and a start pulse injected in the middle of an operation.

// File: rtl/bitser_pkg.sv
package bitser_pkg;

  typedef enum logic [2:0] {
    BS_ADD  = 3'd0,
    BS_SUB  = 3'd1,
    BS_AND  = 3'd2,
    BS_OR   = 3'd3,
    BS_XOR  = 3'd4,
    BS_MOV  = 3'd5,
    BS_LOAD = 3'd6,
    BS_PASS = 3'd7
  } bs_op_e;

endpackage

// File: rtl/bitser_regfile.sv
// Bit-addressable register store: two combinational bit reads, one bit write per clock.
module bitser_regfile #(
  parameter int NREG  = 16,
  parameter int WIDTH = 32,
  localparam int RW   = $clog2(NREG),
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic            clk,
  input  logic            we_i,
  input  logic [RW-1:0]   wr_reg_i,
  input  logic [RW-1:0]   rd_a_reg_i,
  input  logic [RW-1:0]   rd_b_reg_i,
  input  logic [IDXW-1:0] bit_idx_i,
  input  logic            wr_bit_i,
  output logic            a_bit_o,
  output logic            b_bit_o
);

  logic [WIDTH-1:0] row_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_row
    logic row_we;
    assign row_we = we_i && (wr_reg_i == RW'(g));
    always_ff @(posedge clk) begin
      if (row_we) row_q[g][bit_idx_i] <= wr_bit_i;
    end
  end

  assign a_bit_o = row_q[rd_a_reg_i][bit_idx_i];
  assign b_bit_o = row_q[rd_b_reg_i][bit_idx_i];

endmodule

// File: rtl/bitser_alu1.sv
// One-bit logic slice with carry flip-flop.
module bitser_alu1
  import bitser_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   init_i,
  input  logic   carry_init_i,
  input  logic   step_i,
  input  bs_op_e op_i,
  input  logic   a_bit_i,
  input  logic   b_bit_i,
  input  logic   ser_bit_i,
  output logic   res_bit_o
);

  logic carry_q, carry_d;
  logic b_eff, sum_bit, carry_out;

  assign b_eff     = (op_i == BS_SUB) ? ~b_bit_i : b_bit_i;
  assign sum_bit   = a_bit_i ^ b_eff ^ carry_q;
  assign carry_out = (a_bit_i & b_eff) | (carry_q & (a_bit_i ^ b_eff));

  always_comb begin
    unique case (op_i)
      BS_ADD, BS_SUB: res_bit_o = sum_bit;
      BS_AND:         res_bit_o = a_bit_i & b_bit_i;
      BS_OR:          res_bit_o = a_bit_i | b_bit_i;
      BS_XOR:         res_bit_o = a_bit_i ^ b_bit_i;
      BS_LOAD:        res_bit_o = ser_bit_i;
      default:        res_bit_o = a_bit_i;
    endcase
  end

  always_comb begin
    carry_d = carry_q;
    if (init_i)      carry_d = carry_init_i;
    else if (step_i) carry_d = carry_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end

endmodule

// File: rtl/bitser_seq.sv
// Operation sequencer: accepts start when idle, counts bit cycles, pulses done.
module bitser_seq
  import bitser_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int WIDTH = 32,
  localparam int RW   = $clog2(NREG),
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  bs_op_e          op_i,
  input  logic [RW-1:0]   rd_i,
  input  logic [RW-1:0]   ra_i,
  input  logic [RW-1:0]   rb_i,
  output logic            accept_o,
  output bs_op_e          op_o,
  output logic [RW-1:0]   rd_o,
  output logic [RW-1:0]   ra_o,
  output logic [RW-1:0]   rb_o,
  output logic [IDXW-1:0] idx_o,
  output logic            busy_o,
  output logic            last_o,
  output logic            done_o
);

  logic            busy_q, busy_d;
  logic            done_q, done_d;
  logic [IDXW-1:0] idx_q, idx_d;
  bs_op_e          op_q, op_d;
  logic [RW-1:0]   rd_q, rd_d, ra_q, ra_d, rb_q, rb_d;
  logic            accept, last;

  assign accept = start_i && !busy_q;
  assign last   = busy_q && (idx_q == IDXW'(WIDTH - 1));

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    op_d   = op_q;
    rd_d   = rd_q;
    ra_d   = ra_q;
    rb_d   = rb_q;
    done_d = last;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
      op_d   = op_i;
      rd_d   = rd_i;
      ra_d   = ra_i;
      rb_d   = rb_i;
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      op_q   <= BS_ADD;
      rd_q   <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      op_q   <= op_d;
      rd_q   <= rd_d;
      ra_q   <= ra_d;
      rb_q   <= rb_d;
    end
  end

  assign accept_o = accept;
  assign op_o     = op_q;
  assign rd_o     = rd_q;
  assign ra_o     = ra_q;
  assign rb_o     = rb_q;
  assign idx_o    = idx_q;
  assign busy_o   = busy_q;
  assign last_o   = last;
  assign done_o   = done_q;

endmodule

// File: rtl/bitser_datapath.sv
module bitser_datapath
  import bitser_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int WIDTH = 32,
  localparam int RW   = $clog2(NREG),
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [RW-1:0] rd_i,
  input  logic [RW-1:0] ra_i,
  input  logic [RW-1:0] rb_i,
  input  logic          ser_in_i,
  output logic          busy_o,
  output logic          res_bit_o,
  output logic          done_o,
  output logic          zero_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bs_op_e          op_in, op_cur;
  logic            accept, busy, last, done;
  logic [RW-1:0]   rd_cur, ra_cur, rb_cur;
  logic [IDXW-1:0] idx;
  logic            a_bit, b_bit, res_bit;

  assign op_in = bs_op_e'(op_i);

  bitser_seq #(.NREG(NREG), .WIDTH(WIDTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start_i),
    .op_i     (op_in),
    .rd_i     (rd_i),
    .ra_i     (ra_i),
    .rb_i     (rb_i),
    .accept_o (accept),
    .op_o     (op_cur),
    .rd_o     (rd_cur),
    .ra_o     (ra_cur),
    .rb_o     (rb_cur),
    .idx_o    (idx),
    .busy_o   (busy),
    .last_o   (last),
    .done_o   (done)
  );

  bitser_regfile #(.NREG(NREG), .WIDTH(WIDTH)) u_rf (
    .clk        (clk),
    .we_i       (busy),
    .wr_reg_i   (rd_cur),
    .rd_a_reg_i (ra_cur),
    .rd_b_reg_i (rb_cur),
    .bit_idx_i  (idx),
    .wr_bit_i   (res_bit),
    .a_bit_o    (a_bit),
    .b_bit_o    (b_bit)
  );

  bitser_alu1 u_alu (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .init_i       (accept),
    .carry_init_i (op_in == BS_SUB),
    .step_i       (busy),
    .op_i         (op_cur),
    .a_bit_i      (a_bit),
    .b_bit_i      (b_bit),
    .ser_bit_i    (ser_in_i),
    .res_bit_o    (res_bit)
  );

  // sticky OR of result bits, resolved into the zero flag on the last bit
  logic any_q, any_d, zero_q, zero_d;

  always_comb begin
    any_d  = any_q;
    zero_d = zero_q;
    if (accept)    any_d = 1'b0;
    else if (busy) any_d = any_q | res_bit;
    if (last)      zero_d = ~(any_q | res_bit);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      any_q  <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      any_q  <= any_d;
      zero_q <= zero_d;
    end
  end

  assign busy_o    = busy;
  assign res_bit_o = res_bit;
  assign done_o    = done;
  assign zero_o    = zero_q;

endmodule

// File: rtl/bitser_datapath_chk.sv
module bitser_datapath_chk #(
  parameter int WIDTH = 32,
  localparam int CW   = $clog2(WIDTH + 1) + 1
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic zero_o
);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R7
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_q == CW'(WIDTH)));

  // R7
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (run_q < CW'(WIDTH - 1))) |=> busy_o);

  // R9
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(zero_o));

endmodule

bind bitser_datapath bitser_datapath_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .zero_o  (zero_o)
);

// File: tb/bitser_datapath_tb.sv
`timescale 1ns/1ps
module bitser_datapath_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [2:0] op;
  logic [3:0] rd, ra, rb;
  logic       ser;
  logic       busy, res_bit, done, zero;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bitser_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
    .rd_i(rd), .ra_i(ra), .rb_i(rb), .ser_in_i(ser),
    .busy_o(busy), .res_bit_o(res_bit), .done_o(done), .zero_o(zero)
  );

  logic [31:0] vals [8] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
                            32'h7FFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_FFFF};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] s);
    case (o)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd6: return s;
      default: return a;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0: return "R2 add";
      3'd1: return "R3 sub";
      3'd2, 3'd3, 3'd4: return "R4 logic";
      3'd6: return "R6 load";
      default: return "R5 copy";
    endcase
  endfunction

  // Issue one operation, stream bits, check R7/R8 timing. poke injects a start mid-run.
  task automatic run_op(input logic [2:0] o, input logic [3:0] d, input logic [3:0] a,
                        input logic [3:0] b, input logic [31:0] s, input bit poke,
                        output logic [31:0] got, output logic zf);
    int vbad = 0;
    @(negedge clk);
    start = 1'b1; op = o; rd = d; ra = a; rb = b;
    @(negedge clk);
    start = 1'b0;
    got = '0;
    for (int k = 0; k < 32; k++) begin
      if (k > 0) @(negedge clk);
      ser = s[k];
      if (poke && k == 10) begin start = 1'b1; op = 3'd6; rd = 4'd6; end
      if (poke && k == 11) start = 1'b0;
      #1;
      if (!busy || done) vbad++;
      got[k] = res_bit;
    end
    chk("R7 busy during 32 bit cycles", 32'(vbad), 32'd0);
    @(negedge clk); #1;
    chk("R8 done after last bit", {30'd0, done, busy}, 32'd2);
    zf = zero;
    @(negedge clk); #1;
    chk("R8 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic exec(input string req, input logic [2:0] o, input logic [3:0] d,
                      input logic [3:0] a, input logic [3:0] b, input logic [31:0] s,
                      input logic [31:0] exp);
    logic [31:0] got;
    logic zf;
    run_op(o, d, a, b, s, 1'b0, got, zf);
    chk(req, got, exp);
    chk("R9 zero flag", {31'd0, zf}, {31'd0, exp == 32'd0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, e;
    logic zf;
    rst_n = 1'b0; start = 1'b0; op = '0; rd = '0; ra = '0; rb = '0; ser = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R1 reset outputs", {29'd0, busy, done, zero}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R1 idle after reset", {29'd0, busy, done, zero}, 32'd0);

    // R6: fill r8..r15 from the serial input
    for (int i = 0; i < 8; i++) exec("R6 load", 3'd6, 4'(8 + i), 4'd0, 4'd0, vals[i], vals[i]);

    // R2 R3 R4 R5 sweep over all value pairs; copy destination back to verify writeback
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        for (int o = 0; o < 6; o++) begin
          e = model(3'(o), vals[i], vals[j], 32'd0);
          exec(tag(3'(o)), 3'(o), 4'd3, 4'(8 + i), 4'(8 + j), 32'hA5A5_5A5A, e);
          exec({tag(3'(o)), " writeback"}, 3'd5, 4'd4, 4'd3, 4'd0, 32'd0, e);
        end
      end
    end

    // R5: code 7 behaves as copy
    exec("R5 code 7 copy", 3'd7, 4'd3, 4'd14, 4'd10, 32'd0, vals[6]);
    exec("R5 code 7 copy", 3'd7, 4'd3, 4'd8, 4'd10, 32'd0, vals[0]);

    // R10: destination equal to a source
    exec("R6 load", 3'd6, 4'd1, 4'd0, 4'd0, 32'h89AB_CDEF, 32'h89AB_CDEF);
    exec("R6 load", 3'd6, 4'd2, 4'd0, 4'd0, 32'h1111_1111, 32'h1111_1111);
    exec("R10 rd==ra add", 3'd0, 4'd1, 4'd1, 4'd2, 32'd0, 32'h9ABC_DF00);
    exec("R10 rd==rb sub", 3'd1, 4'd2, 4'd1, 4'd2, 32'd0, 32'h89AB_CDEF);
    exec("R10 readback", 3'd5, 4'd0, 4'd2, 4'd0, 32'd0, 32'h89AB_CDEF);

    // R12: self-addition is a left shift
    exec("R6 load", 3'd6, 4'd5, 4'd0, 4'd0, 32'h8000_0001, 32'h8000_0001);
    exec("R12 shift", 3'd0, 4'd5, 4'd5, 4'd5, 32'd0, 32'h0000_0002);
    exec("R12 shift", 3'd0, 4'd5, 4'd5, 4'd5, 32'd0, 32'h0000_0004);
    exec("R12 shift", 3'd0, 4'd7, 4'd14, 4'd14, 32'd0, 32'hBD5B_7DDE);
    exec("R12 shift out", 3'd0, 4'd7, 4'd11, 4'd11, 32'd0, 32'd0);

    // R11: start mid-run is ignored
    exec("R6 load", 3'd6, 4'd6, 4'd0, 4'd0, 32'hCAFE_F00D, 32'hCAFE_F00D);
    run_op(3'd0, 4'd3, 4'd13, 4'd14, 32'h0, 1'b1, got, zf);
    chk("R11 result unaffected", got, vals[5] + vals[6]);
    exec("R11 target unchanged", 3'd5, 4'd4, 4'd6, 4'd0, 32'd0, 32'hCAFE_F00D);
    repeat (3) @(negedge clk);
    #1 chk("R11 idle afterwards", {30'd0, busy, done}, 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule